// File: doc/BRIEF.md
# Encoded Priority Interrupt Controller

This block gathers interrupt requests from up to 31 peripheral sources and presents the most urgent enabled one to a processor core as a single 5-bit code. Each source raises a one-cycle request pulse that sets a sticky pending flag inside the block. A flag counts toward arbitration only while its enable bit is set. Code 0 tells the core that nothing is pending. Codes 1 to 31 name a source, and a lower code means a higher priority.

When the core accepts an interrupt it strobes an acknowledge input. The block latches the code on the I/O clock edge that sees the acknowledge. In the following cycle it drives a one-cycle clear pulse to the matching source and drops that source's pending flag. If a source raises a new request in the same cycle that its flag is being cleared, the new request wins and the flag stays pending. A build option ties the code output to zero for designs that do not use interrupts. A second option picks between a flat scan encoder and a grouped two-level encoder; both give the same codes.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_code is 0, ack_code is 0 and clr_pulse is all zeros.
- R2: A high bit k of req_set at a clock edge sets pending flag k. The flag stays set until it is cleared. While flag k is the only enabled pending flag, irq_code equals k+1.
- R3: A pending source whose src_en bit is low does not affect irq_code, and irq_code is 0 when no enabled flag is pending. The flag is kept, so irq_code shows it again as soon as its enable returns high, in the same cycle.
- R4: When several enabled flags are pending, irq_code is the lowest index plus one. Source 0 maps to code 1 (highest priority) and source 30 maps to code 31 (lowest).
- R5: At a clock edge where irq_ack is high, ack_code takes the value irq_code had just before that edge. At every other edge ack_code holds its value.
- R6: After an edge that captured a nonzero code c, clr_pulse has exactly bit c-1 set for one cycle. Pending flag c-1 is cleared at the next edge, so irq_code then moves to the next pending source.
- R7: If req_set bit k is high in the cycle in which clr_pulse bit k is high, flag k stays pending.
- R8: An acknowledge while irq_code is 0 sets ack_code to 0 and produces no clear pulse.
- R9: With the interrupt option switched off (IRQ_ON = 0), irq_code and clr_pulse are always zero, whatever the inputs.
- R10: The grouped encoder variant produces the same irq_code as the flat scan encoder for every pattern of pending flags and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_io | input | 1 | I/O clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset; clears pending flags, captured code and clear state |
| req_set | input | NUM_SRC | Per-source request pulses; a high bit sets that source's pending flag |
| src_en | input | NUM_SRC | Per-source enables; a source takes part in arbitration only when its bit is high |
| irq_ack | input | 1 | Acknowledge strobe from the core; the current code is captured at this edge |
| irq_code | output | 5 | Encoded highest-priority enabled pending source (0 = none, 1 = highest) |
| ack_code | output | 5 | Code captured at the last acknowledge |
| clr_pulse | output | NUM_SRC | One-hot, one-cycle clear pulse for the acknowledged source |

## Verification
The hardest case to reach from the ports is the collision between a clear and a fresh request from the same source. The request has to land in the one cycle where clr_pulse is high, which is exactly one cycle after the acknowledge edge. The bench gets there by holding the acknowledge for a single cycle and then asserting that source's req_set in the very next cycle. It then confirms that the code for the source is still shown after the clear window has passed. The same sequence, run on a grouped-encoder instance and on an instance with interrupts switched off, checks that the variants agree and that the disabled build stays silent.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
   // Width of the encoded request bus; code 0 is reserved for "idle".
   localparam int unsigned CODE_W  = 5;
   localparam int unsigned MAX_SRC = (1 << CODE_W) - 1;

   typedef logic [CODE_W-1:0] code_t;

   // Encoder structure selection.
   typedef enum logic {
      ENC_FLAT    = 1'b0,
      ENC_GROUPED = 1'b1
   } enc_style_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned NUM_SRC = 31
) (
   input  logic               clk_io,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);
   // One sticky flag per source; a set in the same cycle as a clear wins.
   for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk_io or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (set_i[k]) begin
            flag_q <= 1'b1;
         end else if (clr_i[k]) begin
            flag_q <= 1'b0;
         end
      end
      assign pend_o[k] = flag_q;
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import irq_enc_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 31,
   parameter enc_style_e  ENC_STYLE = ENC_FLAT,
   parameter int unsigned GRP_W     = 8
) (
   input  logic [NUM_SRC-1:0] act_i,
   output code_t              code_o
);
   localparam int unsigned N_GRP = (NUM_SRC + GRP_W - 1) / GRP_W;
   localparam int unsigned PAD_W = N_GRP * GRP_W;
   localparam int unsigned IDX_W = (GRP_W > 1) ? $clog2(GRP_W) : 1;

   if (GRP_W < 2 || GRP_W > 16) begin : g_bad_grp
      $error("irq_prio_enc: GRP_W must lie in 2..16");
   end

   if (ENC_STYLE == ENC_FLAT) begin : g_flat
      // Scan from lowest priority upward so the lowest index is written last.
      always_comb begin
         code_o = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (act_i[i]) begin
               code_o = CODE_W'(i + 1);
            end
         end
      end
   end else begin : g_grouped
      logic [PAD_W-1:0]            act_pad;
      logic [N_GRP-1:0]            grp_hit;
      logic [N_GRP-1:0][IDX_W-1:0] grp_idx;

      always_comb begin
         act_pad = '0;
         act_pad[NUM_SRC-1:0] = act_i;
      end

      // First level: lowest active line inside each group.
      for (genvar g = 0; g < N_GRP; g++) begin : g_grp
         logic [GRP_W-1:0] slice;
         logic [IDX_W-1:0] idx;
         assign slice = act_pad[g*GRP_W +: GRP_W];
         always_comb begin
            idx = '0;
            for (int j = GRP_W - 1; j >= 0; j--) begin
               if (slice[j]) begin
                  idx = IDX_W'(j);
               end
            end
         end
         assign grp_hit[g] = |slice;
         assign grp_idx[g] = idx;
      end

      // Second level: lowest group with any active line.
      always_comb begin
         code_o = '0;
         for (int g = N_GRP - 1; g >= 0; g--) begin
            if (grp_hit[g]) begin
               code_o = CODE_W'(g * GRP_W) + CODE_W'(grp_idx[g]) + CODE_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/irq_ack_track.sv
module irq_ack_track
   import irq_enc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 31
) (
   input  logic               clk_io,
   input  logic               rst_n,
   input  logic               ack_i,
   input  code_t              code_i,
   output code_t              ack_code_o,
   output logic [NUM_SRC-1:0] clr_o
);
   code_t cap_q;
   logic  clr_vld_q;

   always_ff @(posedge clk_io or negedge rst_n) begin
      if (!rst_n) begin
         cap_q     <= '0;
         clr_vld_q <= 1'b0;
      end else begin
         clr_vld_q <= ack_i && (code_i != '0);
         if (ack_i) begin
            cap_q <= code_i;
         end
      end
   end

   assign ack_code_o = cap_q;

   // Decode the captured code back to a one-hot clear strobe.
   for (genvar k = 0; k < NUM_SRC; k++) begin : g_clr
      assign clr_o[k] = clr_vld_q && (cap_q == CODE_W'(k + 1));
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_enc_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 31,
   parameter bit          IRQ_ON    = 1'b1,
   parameter enc_style_e  ENC_STYLE = ENC_FLAT,
   parameter int unsigned GRP_W     = 8
) (
   input  logic               clk_io,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_set,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               irq_ack,
   output logic [4:0]         irq_code,
   output logic [4:0]         ack_code,
   output logic [NUM_SRC-1:0] clr_pulse
);
   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_cnt
      $error("irq_prio_ctrl: NUM_SRC must lie in 1..%0d", MAX_SRC);
   end
   if (CODE_W != 5) begin : g_bad_code
      $error("irq_prio_ctrl: port width assumes a 5-bit code");
   end

   if (IRQ_ON) begin : g_active
      logic [NUM_SRC-1:0] pend;
      logic [NUM_SRC-1:0] clr;
      logic [NUM_SRC-1:0] act;
      code_t              code;
      code_t              cap;

      irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
         .clk_io (clk_io),
         .rst_n  (rst_n),
         .set_i  (req_set),
         .clr_i  (clr),
         .pend_o (pend)
      );

      assign act = pend & src_en;

      irq_prio_enc #(
         .NUM_SRC   (NUM_SRC),
         .ENC_STYLE (ENC_STYLE),
         .GRP_W     (GRP_W)
      ) u_enc (
         .act_i  (act),
         .code_o (code)
      );

      irq_ack_track #(.NUM_SRC(NUM_SRC)) u_ack (
         .clk_io     (clk_io),
         .rst_n      (rst_n),
         .ack_i      (irq_ack),
         .code_i     (code),
         .ack_code_o (cap),
         .clr_o      (clr)
      );

      assign irq_code  = code;
      assign ack_code  = cap;
      assign clr_pulse = clr;
   end else begin : g_idle
      // Interrupts unused: hold the request bus quiet.
      assign irq_code  = '0;
      assign ack_code  = '0;
      assign clr_pulse = '0;
   end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int unsigned NUM_SRC = 31,
   parameter bit          IRQ_ON  = 1'b1
) (
   input logic               clk_io,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_en,
   input logic               irq_ack,
   input logic [4:0]         irq_code,
   input logic [4:0]         ack_code,
   input logic [NUM_SRC-1:0] clr_pulse
);
   // R5: acknowledge captures the code that was presented
   a_r5_capture: assert property (@(posedge clk_io) disable iff (!rst_n)
      irq_ack |=> (ack_code == $past(irq_code)));

   // R5: captured code holds without acknowledge
   a_r5_hold: assert property (@(posedge clk_io) disable iff (!rst_n)
      !irq_ack |=> $stable(ack_code));

   // R6: at most one source cleared at a time
   a_r6_onehot: assert property (@(posedge clk_io) disable iff (!rst_n)
      $onehot0(clr_pulse));

   // R6, R8: a clear only follows an acknowledge of a nonzero code
   a_r6_cause: assert property (@(posedge clk_io) disable iff (!rst_n)
      (|clr_pulse) |-> ($past(irq_ack) && ($past(irq_code) != 5'd0)));

   // R6: pulse lasts one cycle unless acknowledged again
   a_r6_single: assert property (@(posedge clk_io) disable iff (!rst_n)
      ((|clr_pulse) && !irq_ack) |=> (clr_pulse == '0));

   // R3: a presented code always belongs to an enabled source
   a_r3_enabled: assert property (@(posedge clk_io) disable iff (!rst_n)
      (irq_code != 5'd0) |-> src_en[irq_code - 5'd1]);

   // R4: code never names a source beyond the configured count
   a_r4_range: assert property (@(posedge clk_io) disable iff (!rst_n)
      irq_code <= 5'(NUM_SRC));

   // R9: disabled build stays silent
   a_r9_quiet: assert property (@(posedge clk_io) disable iff (!rst_n)
      !IRQ_ON |-> ((irq_code == 5'd0) && (clr_pulse == '0)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .NUM_SRC (NUM_SRC),
   .IRQ_ON  (IRQ_ON)
) u_chk (
   .clk_io    (clk_io),
   .rst_n     (rst_n),
   .src_en    (src_en),
   .irq_ack   (irq_ack),
   .irq_code  (irq_code),
   .ack_code  (ack_code),
   .clr_pulse (clr_pulse)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
   import irq_enc_pkg::*;

   localparam int unsigned NS = 31;
   localparam logic [NS-1:0] ALL = {NS{1'b1}};

   typedef struct {
      logic [4:0]    code;
      logic [4:0]    ackc;
      logic [NS-1:0] clr;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] req = '0;
   logic [NS-1:0] en = ALL;
   logic          ack = 1'b0;

   logic [4:0]    code_a, ackc_a, code_g, ackc_g, code_o, ackc_o;
   logic [NS-1:0] clr_a, clr_g, clr_o;

   int checks = 0;
   int errors = 0;
   exp_t q[$];

   always #4 clk = ~clk; // 125 MHz

   irq_prio_ctrl #(.NUM_SRC(NS)) i_irq_prio_ctrl (
      .clk_io(clk), .rst_n(rst_n), .req_set(req), .src_en(en), .irq_ack(ack),
      .irq_code(code_a), .ack_code(ackc_a), .clr_pulse(clr_a));

   irq_prio_ctrl #(.NUM_SRC(NS), .ENC_STYLE(ENC_GROUPED)) i_irq_prio_ctrl_grp (
      .clk_io(clk), .rst_n(rst_n), .req_set(req), .src_en(en), .irq_ack(ack),
      .irq_code(code_g), .ack_code(ackc_g), .clr_pulse(clr_g));

   irq_prio_ctrl #(.NUM_SRC(NS), .IRQ_ON(1'b0)) i_irq_prio_ctrl_off (
      .clk_io(clk), .rst_n(rst_n), .req_set(req), .src_en(en), .irq_ack(ack),
      .irq_code(code_o), .ack_code(ackc_o), .clr_pulse(clr_o));

   function automatic logic [NS-1:0] bit_of(input int k);
      return NS'(1) << k;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [NS-1:0] act, input logic [NS-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Driver: apply inputs just after an edge, queue the outputs expected in that window.
   task automatic step(input logic [NS-1:0] r, input logic [NS-1:0] e, input logic a,
                       input logic [4:0] xc, input logic [4:0] xa,
                       input logic [NS-1:0] xclr, input string tag);
      exp_t it;
      @(posedge clk);
      #1;
      req = r; en = e; ack = a;
      it.code = xc; it.ackc = xa; it.clr = xclr; it.tag = tag;
      q.push_back(it);
   endtask

   // Monitor: compare mid-cycle.
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            chk(code_a == it.code, it.tag, "irq_code", NS'(code_a), NS'(it.code));
            chk(ackc_a == it.ackc, it.tag, "ack_code", NS'(ackc_a), NS'(it.ackc));
            chk(clr_a == it.clr, it.tag, "clr_pulse", clr_a, it.clr);
            chk(code_g == it.code, "R10", "grouped irq_code", NS'(code_g), NS'(it.code));
            chk(clr_g == it.clr, "R10", "grouped clr_pulse", clr_g, it.clr);
            chk((code_o == 5'd0) && (clr_o == '0) && (ackc_o == 5'd0), "R9",
                "disabled outputs", NS'(code_o) | clr_o, '0);
         end
      end
   end

   // Watchdog
   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      step('0, ALL, 0, 5'd0, 5'd0, '0, "R1");
      // R2 single source 5 -> code 6
      step(bit_of(5), ALL, 0, 5'd0, 5'd0, '0, "R2");
      step('0, ALL, 0, 5'd6, 5'd0, '0, "R2");
      // R3 masking hides, unmask restores
      step('0, ALL & ~bit_of(5), 0, 5'd0, 5'd0, '0, "R3");
      step('0, ALL, 0, 5'd6, 5'd0, '0, "R3");
      // R4 source 2 outranks source 5
      step(bit_of(2), ALL, 0, 5'd6, 5'd0, '0, "R4");
      step('0, ALL, 0, 5'd3, 5'd0, '0, "R4");
      // R5/R6 acknowledge code 3
      step('0, ALL, 1, 5'd3, 5'd0, '0, "R5");
      step('0, ALL, 0, 5'd3, 5'd3, bit_of(2), "R6");
      step('0, ALL, 0, 5'd6, 5'd3, '0, "R6");
      // R7 set collides with clear of source 5
      step('0, ALL, 1, 5'd6, 5'd3, '0, "R5");
      step(bit_of(5), ALL, 0, 5'd6, 5'd6, bit_of(5), "R7");
      step('0, ALL, 0, 5'd6, 5'd6, '0, "R7");
      // clear source 5 for real
      step('0, ALL, 1, 5'd6, 5'd6, '0, "R5");
      step('0, ALL, 0, 5'd6, 5'd6, bit_of(5), "R6");
      step('0, ALL, 0, 5'd0, 5'd6, '0, "R6");
      // R8 acknowledge with nothing pending
      step('0, ALL, 1, 5'd0, 5'd6, '0, "R8");
      step('0, ALL, 0, 5'd0, 5'd0, '0, "R8");
      // R4 boundaries: source 30 (code 31) and source 0 (code 1)
      step(bit_of(30), ALL, 0, 5'd0, 5'd0, '0, "R4");
      step('0, ALL, 0, 5'd31, 5'd0, '0, "R4");
      step(bit_of(0), ALL, 0, 5'd31, 5'd0, '0, "R4");
      step('0, ALL, 0, 5'd1, 5'd0, '0, "R4");
      step('0, ALL, 1, 5'd1, 5'd0, '0, "R5");
      step('0, ALL, 0, 5'd1, 5'd1, bit_of(0), "R6");
      step('0, ALL, 0, 5'd31, 5'd1, '0, "R6");
      step('0, ALL, 1, 5'd31, 5'd1, '0, "R5");
      step('0, ALL, 0, 5'd31, 5'd31, bit_of(30), "R6");
      step('0, ALL, 0, 5'd0, 5'd31, '0, "R2");
      @(posedge clk);
      #6;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule